// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a serial memory on a two-wire bus. It receives the sampled clock and data lines, finds start and stop conditions, shifts in the selection byte, the word-address byte and any data bytes, and answers each accepted byte by pulling the data line low for the ninth clock. It does not store anything itself. A neighbouring address/page controller holds the memory and the current address. This engine hands that controller single-cycle strobes: load a word address, write a byte, step to the next read location, and begin the self-timed write after a stop. When the host reads, the engine shifts out the byte the controller presents.

The selection byte is matched only on its four most significant bits, which must be 1,0,1,0. The next three bits are not a chip identity. They are the high-order page bits and are placed above the eight-bit word address. The last bit selects direction. While the controller reports a write cycle in progress, the engine answers nothing, so a host can probe the bus repeatedly until an acknowledge comes back. Both lines are re-timed into the system clock by two-flop synchronisers, and that clock runs many times faster than the serial clock.

Top module: `twt_target`

## Requirements
- R1: A start condition (data falling while the serial clock is high) in any state abandons the byte in progress, clears any pending write, and restarts reception of the selection byte.
- R2: A selection byte whose top four bits are 1,0,1,0 is acknowledged (data held low during the ninth clock) whatever its three page bits; any other top nibble gets no acknowledge, and the engine then ignores the bus, including later bytes that would match, until the next start.
- R3: While `busy` is high, a selection byte gets no acknowledge and no strobe is issued; once `busy` is low again, a new start and selection byte are acknowledged.
- R4: In a write transfer the byte after the selection byte is acknowledged and issues one `addrLoad` pulse with `addrValue` = {page bits, received byte}.
- R5: Every further byte of a write transfer is acknowledged and issues one `wrStrobe` pulse with the byte on `wrData`; data bits are taken on rising serial clock edges, most significant bit first.
- R6: A stop condition (data rising while the serial clock is high) after at least one data byte issues one `commit` pulse; a stop with no data byte since the last start issues none.
- R7: In a read transfer the engine shifts out `rdData` most significant bit first, changing the data line only while the serial clock is low. A '1' bit is sent by releasing the line.
- R8: A host acknowledge on the ninth clock of a read byte issues one `rdAdvance` pulse, and the next byte follows. A missing host acknowledge leaves the line released and ends the read until the next start.
- R9: During and after reset the data line is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| busy | input | 1 | Controller is in a self-timed write cycle |
| rdData | input | 8 | Byte at the controller's current address |
| sdaPull | output | 1 | 1 = pull the data line low (open-drain enable) |
| addrLoad | output | 1 | Pulse: load `addrValue` as current address |
| addrValue | output | 11 | Page bits above the received word address |
| wrStrobe | output | 1 | Pulse: write `wrData` at the current address |
| wrData | output | 8 | Received data byte |
| rdAdvance | output | 1 | Pulse: host acknowledged, step the read address |
| commit | output | 1 | Pulse: stop after write data, start the write cycle |

## Verification
Every line edge reaches the engine two synchronising flops plus one edge-detect flop after the pin changes. A strobe therefore appears about four system cycles after the rising serial clock edge that completes its byte. The acknowledge or data level appears about four cycles after the falling edge. The bench holds each serial clock phase for eight system cycles. It samples the data line in the middle of the high phase, and it compares strobe counts and captured values only after the ninth clock of a byte has finished, by which time every strobe from that byte has settled.

// File: rtl/twt_pkg.sv
package twt_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 4;
  localparam int PAGE_W = BYTE_W - PRE_W - 1;
  localparam int ADDR_W = PAGE_W + BYTE_W;
  localparam logic [PRE_W-1:0] PREAMBLE = 4'b1010;

  // strobes from control to datapath
  typedef struct packed {
    logic active;    // count serial bits
    logic ackArm;    // pull low during the ninth clock
    logic txActive;  // shift read data onto the line
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEVICE, S_WORD, S_WRITE, S_READ
  } engState_t;
endpackage

// File: rtl/twt_sync.sv
module twt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= din;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/twt_datapath.sv
module twt_datapath
  import twt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic              ninthDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              hostAck,
  output logic              sdaPull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(BYTE_W - 1);

  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-2:0] txShift;

  twt_sync #(.STAGES(SYNC_STAGES)) uSyncScl (.clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  twt_sync #(.STAGES(SYNC_STAGES)) uSyncSda (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startDet  = sclS & sclP & sdaP & ~sdaS;
  assign stopDet   = sclS & sclP & ~sdaP & sdaS;
  assign byteDone  = sclRise & ctl.active & (bitCnt == PRE_LAST);
  assign ninthDone = sclRise & ctl.active & (bitCnt == LAST);
  assign rxByte    = {rxShift, sdaS};
  assign hostAck   = ~sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      sdaPull <= 1'b0;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
      if (startDet || stopDet) begin
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else begin
        if (sclRise && ctl.active) begin
          if (bitCnt == LAST) begin
            bitCnt <= '0;
          end else begin
            bitCnt  <= bitCnt + 1'b1;
            rxShift <= {rxShift[BYTE_W-3:0], sdaS};
          end
        end
        if (sclFall) begin
          if (bitCnt == LAST) begin
            sdaPull <= ctl.ackArm;
          end else if (ctl.txActive) begin
            if (bitCnt == '0) begin
              sdaPull <= ~rdData[BYTE_W-1];
              txShift <= rdData[BYTE_W-2:0];
            end else begin
              sdaPull <= ~txShift[BYTE_W-2];
              txShift <= {txShift[BYTE_W-3:0], 1'b0};
            end
          end else begin
            sdaPull <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twt_control.sv
module twt_control
  import twt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic              ninthDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              hostAck,
  input  logic              busy,
  output dpCtl_t            ctl,
  output logic              addrLoad,
  output logic [ADDR_W-1:0] addrValue,
  output logic              wrStrobe,
  output logic [BYTE_W-1:0] wrData,
  output logic              rdAdvance,
  output logic              commit
);
  engState_t state;
  logic [PAGE_W-1:0] pageBits;
  logic rwBit, ackPending, gotData;

  assign ctl = '{active:   (state != S_IDLE),
                 ackArm:   ackPending,
                 txActive: (state == S_READ)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pageBits   <= '0;
      rwBit      <= 1'b0;
      ackPending <= 1'b0;
      gotData    <= 1'b0;
      addrLoad   <= 1'b0;
      addrValue  <= '0;
      wrStrobe   <= 1'b0;
      wrData     <= '0;
      rdAdvance  <= 1'b0;
      commit     <= 1'b0;
    end else begin
      addrLoad  <= 1'b0;
      wrStrobe  <= 1'b0;
      rdAdvance <= 1'b0;
      commit    <= 1'b0;
      if (startDet) begin
        state      <= S_DEVICE;
        ackPending <= 1'b0;
        gotData    <= 1'b0;
      end else if (stopDet) begin
        commit     <= gotData;
        gotData    <= 1'b0;
        ackPending <= 1'b0;
        state      <= S_IDLE;
      end else if (byteDone) begin
        unique case (state)
          S_DEVICE: begin
            if (rxByte[BYTE_W-1 -: PRE_W] == PREAMBLE && !busy) begin
              ackPending <= 1'b1;
              pageBits   <= rxByte[PAGE_W:1];
              rwBit      <= rxByte[0];
            end else begin
              state <= S_IDLE;
            end
          end
          S_WORD: begin
            addrLoad   <= 1'b1;
            addrValue  <= {pageBits, rxByte};
            ackPending <= 1'b1;
          end
          S_WRITE: begin
            wrStrobe   <= 1'b1;
            wrData     <= rxByte;
            gotData    <= 1'b1;
            ackPending <= 1'b1;
          end
          default: ;
        endcase
      end else if (ninthDone) begin
        ackPending <= 1'b0;
        unique case (state)
          S_DEVICE: state <= rwBit ? S_READ : S_WORD;
          S_WORD:   state <= S_WRITE;
          S_READ: begin
            if (hostAck) rdAdvance <= 1'b1;
            else         state <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twt_target.sv
module twt_target
  import twt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaPull,
  output logic              addrLoad,
  output logic [ADDR_W-1:0] addrValue,
  output logic              wrStrobe,
  output logic [BYTE_W-1:0] wrData,
  output logic              rdAdvance,
  output logic              commit
);
  dpCtl_t ctl;
  logic startDet, stopDet, byteDone, ninthDone, hostAck;
  logic [BYTE_W-1:0] rxByte;

  twt_datapath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .rdData(rdData), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .ninthDone(ninthDone), .rxByte(rxByte),
    .hostAck(hostAck), .sdaPull(sdaPull)
  );

  twt_control uCtl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .ninthDone(ninthDone), .rxByte(rxByte),
    .hostAck(hostAck), .busy(busy), .ctl(ctl), .addrLoad(addrLoad),
    .addrValue(addrValue), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdAdvance(rdAdvance), .commit(commit)
  );
endmodule

// File: rtl/twt_target_chk.sv
module twt_target_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic busy,
  input logic sdaPull,
  input logic addrLoad,
  input logic wrStrobe,
  input logic rdAdvance,
  input logic commit
);
  // no strobe reaches the controller during its write cycle
  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!addrLoad && !wrStrobe));

  assert_addr_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> !addrLoad);

  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrLoad, wrStrobe, rdAdvance, commit}));

  assert_commit_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !sdaPull);

  assert_line_moves_clock_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPull) |-> !sclIn);

  assert_advance_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdAdvance |-> !sdaPull);

  always @(posedge clk)
    if (!rstN) assert_reset_quiet_R9: assert (!sdaPull || $isunknown(sdaPull));
endmodule

bind twt_target twt_target_chk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .busy(busy), .sdaPull(sdaPull),
  .addrLoad(addrLoad), .wrStrobe(wrStrobe), .rdAdvance(rdAdvance), .commit(commit)
);

// File: tb/sim_twt_target.sv
module sim_twt_target;
  localparam int HP = 8;
  localparam int BUSY_CYC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hsda = 1'b1;
  logic busy;
  logic [7:0] rdData;
  logic sdaPull, addrLoad, wrStrobe, rdAdvance, commit;
  logic [10:0] addrValue;
  logic [7:0] wrData;
  wire bus = hsda & ~sdaPull;

  int nVec = 0, nFail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  twt_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(bus), .busy(busy), .rdData(rdData),
    .sdaPull(sdaPull), .addrLoad(addrLoad), .addrValue(addrValue), .wrStrobe(wrStrobe),
    .wrData(wrData), .rdAdvance(rdAdvance), .commit(commit)
  );

  // controller model
  logic [7:0] mem [0:2047];
  logic [10:0] curAddr = '0;
  int busyCnt = 0;
  int nAddr = 0, nWr = 0, nAdv = 0, nCommit = 0;
  logic [10:0] lastAddr = '0;
  assign busy = (busyCnt != 0);
  assign rdData = mem[curAddr];

  initial for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 13 + 7);

  always @(posedge clk) begin
    if (addrLoad) begin curAddr <= addrValue; lastAddr <= addrValue; nAddr <= nAddr + 1; end
    if (wrStrobe) begin
      mem[curAddr] <= wrData;
      curAddr <= {curAddr[10:4], curAddr[3:0] + 4'd1};
      nWr <= nWr + 1;
    end
    if (rdAdvance) begin curAddr <= curAddr + 11'd1; nAdv <= nAdv + 1; end
    if (commit) begin busyCnt <= BUSY_CYC; nCommit <= nCommit + 1; end
    else if (busyCnt != 0) busyCnt <= busyCnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hStart();
    waitc(2); hsda = 1'b1; waitc(HP); scl = 1'b1; waitc(HP);
    hsda = 1'b0; waitc(HP); scl = 1'b0;
  endtask

  task automatic hStop();
    waitc(2); hsda = 1'b0; waitc(HP); scl = 1'b1; waitc(HP);
    hsda = 1'b1; waitc(HP);
  endtask

  task automatic sendBit(input logic b);
    waitc(2); hsda = b; waitc(HP); scl = 1'b1; waitc(HP); scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    waitc(2); hsda = 1'b1; waitc(HP); scl = 1'b1; waitc(HP / 2);
    ack = ~bus; waitc(HP / 2); scl = 1'b0;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      waitc(2); hsda = 1'b1; waitc(HP); scl = 1'b1; waitc(HP / 2);
      d[i] = bus; waitc(HP / 2); scl = 1'b0;
    end
    sendBit(~giveAck);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int c0;
    waitc(5);
    rstN = 1'b1;
    waitc(5);
    // reset state
    chk("R9 line released", int'(sdaPull), 0);
    chk("R9 no strobes", int'({addrLoad, wrStrobe, rdAdvance, commit}), 0);

    // preamble sweep: only nibble 1010 answers, page bits free
    for (int n = 0; n < 16; n++) begin
      hStart(); sendByte({4'(n), 3'(n), 1'b0}, ack); hStop();
      chk("R2 preamble ack", int'(ack), int'(n == 10));
    end
    chk("R6 no commit without data", nCommit, 0);
    chk("R2 no address load", nAddr, 0);

    // after a mismatch the rest of the frame is ignored
    hStart(); sendByte(8'h52, ack);
    chk("R2 mismatch nack", int'(ack), 0);
    sendByte(8'hA0, ack);
    chk("R2 ignored until start", int'(ack), 0);
    sendByte(8'h33, ack);
    chk("R2 ignored byte", int'(ack), 0);
    hStop();
    chk("R2 no strobes after mismatch", nAddr + nWr, 0);

    // page sweep: write two bytes on every page, then poll
    for (int p = 0; p < 8; p++) begin
      c0 = nCommit;
      hStart(); sendByte({4'hA, 3'(p), 1'b0}, ack);
      chk("R2 select ack", int'(ack), 1);
      sendByte(8'(p * 16 + 4), ack);
      chk("R4 word ack", int'(ack), 1);
      chk("R4 address value", int'(lastAddr), p * 256 + p * 16 + 4);
      sendByte(8'(p * 37 + 1), ack);
      chk("R5 data ack", int'(ack), 1);
      sendByte(8'(p * 37 + 2), ack);
      chk("R5 data ack 2", int'(ack), 1);
      chk("R5 bytes written", int'(mem[p * 256 + p * 16 + 5]), (p * 37 + 2) & 255);
      hStop();
      waitc(4);
      chk("R6 commit after data", nCommit, c0 + 1);
      hStart(); sendByte({4'hA, 3'(p), 1'b0}, ack); hStop();
      chk("R3 busy nack", int'(ack), 0);
      chk("R6 stop without data", nCommit, c0 + 1);
      while (busy) @(negedge clk);
      hStart(); sendByte({4'hA, 3'(p), 1'b0}, ack); hStop();
      chk("R3 ack after busy", int'(ack), 1);
    end

    // random read with sequential continuation
    for (int p = 0; p < 8; p++) begin
      c0 = nAdv;
      hStart(); sendByte({4'hA, 3'(p), 1'b0}, ack);
      sendByte(8'(p * 16 + 4), ack);
      hStart(); sendByte({4'hA, 3'(7 - p), 1'b1}, ack);
      chk("R2 read select ack", int'(ack), 1);
      recvByte(1'b1, d);
      chk("R7 first read byte", int'(d), (p * 37 + 1) & 255);
      recvByte(1'b0, d);
      chk("R8 next byte after ack", int'(d), (p * 37 + 2) & 255);
      waitc(6);
      chk("R8 released after nack", int'(sdaPull), 0);
      chk("R8 one advance", nAdv, c0 + 1);
      hStop();
    end

    // current-address read: last read left address at page 7 offset 5
    hStart(); sendByte(8'hA1, ack); recvByte(1'b0, d); hStop();
    chk("R7 current address read", int'(d), (7 * 37 + 2) & 255);

    // start in the middle of a selection byte
    hStart(); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    hStart(); sendByte(8'hA6, ack);
    chk("R1 restart select ack", int'(ack), 1);
    sendByte(8'h77, ack);
    chk("R1 restart address", int'(lastAddr), 3 * 256 + 8'h77);
    hStop();

    // start in the middle of a data byte drops the pending write
    c0 = nCommit;
    hStart(); sendByte(8'hA0, ack); sendByte(8'h20, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    hStart(); sendByte(8'hA0, ack);
    chk("R1 select after abort", int'(ack), 1);
    hStop();
    waitc(4);
    chk("R1 aborted byte not written", nWr, 16);
    chk("R1 no commit after abort", nCommit, c0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule